// File: doc/BRIEF.md
# DDC EDID Reader

This block is a small I2C master that fetches display identification data over a DDC link and places the received bytes in a receive FIFO. The host sets up several values: a segment number, a slave address (the 7-bit address sits in bits 7:1), a word offset and a 10-bit byte count. It then writes one 4-bit command code. The engine runs the whole bus transaction from that single code. For a segment-addressed fetch, it first writes the segment pointer at I2C address 0x60. It then writes the word offset to the slave, sends a repeated start and reads the requested number of bytes. While it reads, the host drains bytes through the data port.

For display block k, the host loads segment k/2 and uses word offset 0x80 when k is odd, or 0x00 when k is even. A 128-byte count fetches one block. The engine also has two other bus commands. The first clocks SCL nine times to free a slave that is holding SDA low. The second is an abort that ends any transfer with a STOP. An 8-bit status word reports progress and faults. SCL runs at one quarter-bit every `CLK_DIV` system clocks. The engine holds SCL low before a byte when the FIFO has no room left.

Top module: `ddc_edid_reader`

## Requirements
- R1: Command codes are 0x2 (plain read), 0x4 (segment read), 0xA (bus recovery), 0x9 (FIFO clear) and 0xF (abort). Any other code is ignored. While a command is running, every code except 0xF is ignored.
- R2: Status bit 4 (busy) is 1 from the cycle after an accepted command until that command completes. This includes clear (busy for one cycle), recovery and abort. After reset the status word is 0x04.
- R3: A plain read performs these bus steps in order:
  - START, then the address byte with R/W=0, then the offset byte;
  - a repeated START, then the address byte with R/W=1;
  - the requested number of data bytes, which enter the FIFO in bus order.
- R4: A segment read begins with START, address byte 0x60 and the segment byte. It then sends a repeated START and continues exactly as R3, so the data comes from the selected segment.
- R5: The byte count is {cnt_hi, cnt_lo} (10 bits). The master ACKs every data byte except the last, which gets a NACK and then a STOP. A count of 0 writes only the offset and then sends STOP.
- R6: A byte that is not acknowledged sets status bit 5, sends STOP and ends the command. Bits 5 and 6 clear when the next read or recovery command is accepted.
- R7: If SCL stays low for `LOW_TIMEOUT` cycles after release, or SDA is low when a START is attempted, status bit 6 is set. Both lines are then released and the command ends.
- R8: Recovery drives nine SCL pulses with SDA released, then a STOP.
- R9: Status bit 2 is 1 while the FIFO is empty. A pop returns the oldest byte on `data_out`. When all `FIFO_DEPTH` entries are full, SCL is held low before the next byte and no byte is lost.
- R10: The clear command, when idle, empties the FIFO.
- R11: Abort ends a running transfer with a STOP. Busy then falls and both lines are left released.
- R12: One SCL period lasts 4*`CLK_DIV` system clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| cmd_wr | input | 1 | Command write strobe |
| cmd | input | 4 | Command code |
| seg_reg | input | 8 | Segment number |
| addr_reg | input | 8 | Slave address in bits 7:1 |
| offs_reg | input | 8 | Word offset |
| cnt_lo | input | 8 | Byte count bits 7:0 |
| cnt_hi | input | 2 | Byte count bits 9:8 |
| data_rd | input | 1 | Pop one byte from the FIFO |
| data_out | output | 8 | Oldest FIFO byte |
| status | output | 8 | Bit 6 bus low, bit 5 no ack, bit 4 busy, bit 2 FIFO empty |
| scl_o | output | 1 | SCL drive, 1 = released |
| scl_i | input | 1 | SCL line level |
| sda_o | output | 1 | SDA drive, 1 = released |
| sda_i | input | 1 | SDA line level |

## Verification
The bench builds the block with `CLK_DIV`=2, `FIFO_DEPTH`=16 and `LOW_TIMEOUT`=64. With these values one byte takes 72 clocks. As a result, a full 128-byte block, a 300-byte read that uses the count's upper bits and the wrap of the slave's word pointer all fit in a short run. A 20-byte read without draining overfills the 16-entry FIFO, which exercises the SCL hold. The short timeout lets both stuck-bus faults and the recovery that follows be checked within a few hundred cycles.

// File: rtl/ddc_edid_reader.sv
module ddc_edid_reader #(
  parameter int CLK_DIV     = 500,
  parameter int FIFO_DEPTH  = 16,
  parameter int LOW_TIMEOUT = 50000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_wr,
  input  logic [3:0] cmd,
  input  logic [7:0] seg_reg,
  input  logic [7:0] addr_reg,
  input  logic [7:0] offs_reg,
  input  logic [7:0] cnt_lo,
  input  logic [1:0] cnt_hi,
  input  logic       data_rd,
  output logic [7:0] data_out,
  output logic [7:0] status,
  output logic       scl_o,
  input  logic       scl_i,
  output logic       sda_o,
  input  logic       sda_i
);
  localparam int DW = $clog2(CLK_DIV) + 1;
  localparam int LW = $clog2(LOW_TIMEOUT + 1);
  localparam int AW = (FIFO_DEPTH > 1) ? $clog2(FIFO_DEPTH) : 1;

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_CLR} state_t;
  typedef enum logic [2:0] {K_START, K_TX, K_RX, K_STOP, K_RCV} kind_t;

  state_t        state;
  kind_t         kind;
  logic [3:0]    stp, nxt, bitn;
  logic [1:0]    q;
  logic [DW-1:0] div;
  logic [LW-1:0] lowc;
  logic [7:0]    sh, seg_q, addr_q, off_q, txb;
  logic [9:0]    rem;
  logic          f_low, f_nack, scl_d, sda_d, last_bit;
  logic          abort_c, hold_scl, hold_fifo, tick, push, pop, full, empty;

  logic [7:0]    mem [FIFO_DEPTH];
  logic [AW-1:0] wp, rp;
  logic [AW:0]   cnt;

  always_comb begin
    case (stp)
      4'd0, 4'd3, 4'd6:             kind = K_START;
      4'd1, 4'd2, 4'd4, 4'd5, 4'd7: kind = K_TX;
      4'd8:                         kind = K_RX;
      4'd10:                        kind = K_RCV;
      default:                      kind = K_STOP;
    endcase
    case (stp)
      4'd1:    txb = 8'h60;
      4'd2:    txb = seg_q;
      4'd4:    txb = {addr_q[7:1], 1'b0};
      4'd5:    txb = off_q;
      4'd7:    txb = {addr_q[7:1], 1'b1};
      default: txb = 8'h00;
    endcase
    case (stp)
      4'd5:    nxt = (rem == 10'd0) ? 4'd9 : 4'd6;
      4'd8:    nxt = (rem == 10'd1) ? 4'd9 : 4'd8;
      4'd10:   nxt = 4'd9;
      default: nxt = stp + 4'd1;
    endcase
  end

  assign last_bit = (kind == K_START || kind == K_STOP) ? 1'b1 : (bitn == 4'd8);

  always_comb begin
    scl_d = 1'b1;
    sda_d = 1'b1;
    if (state == S_RUN) begin
      case (kind)
        K_START: begin scl_d = (q == 2'd1) || (q == 2'd2); sda_d = (q <= 2'd1); end
        K_STOP:  begin scl_d = (q != 2'd0); sda_d = (q >= 2'd2); end
        default: begin
          scl_d = (q == 2'd1) || (q == 2'd2);
          if (kind == K_TX && bitn < 4'd8) sda_d = txb[3'(4'd7 - bitn)];
          else if (kind == K_RX && bitn == 4'd8) sda_d = (rem == 10'd1);
        end
      endcase
    end
  end

  assign scl_o     = scl_d;
  assign sda_o     = sda_d;
  assign full      = (cnt == (AW+1)'(FIFO_DEPTH));
  assign empty     = (cnt == '0);
  assign abort_c   = (state == S_RUN) && cmd_wr && (cmd == 4'hF);
  assign hold_scl  = (state == S_RUN) && scl_d && !scl_i;
  assign hold_fifo = (state == S_RUN) && (kind == K_RX) && (bitn == 4'd0) && (q == 2'd0) && full;
  assign tick      = (state == S_RUN) && !abort_c && !hold_scl && !hold_fifo && (div == '0);
  assign push      = tick && (kind == K_RX) && (q == 2'd3) && (bitn == 4'd7);
  assign pop       = data_rd && !empty;
  assign data_out  = mem[rp];
  assign status    = {1'b0, f_low, f_nack, state != S_IDLE, 1'b0, empty, 2'b00};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE; stp <= 4'd9; q <= '0; bitn <= '0; div <= '0; lowc <= '0;
      sh <= '0; rem <= '0; seg_q <= '0; addr_q <= '0; off_q <= '0;
      f_low <= 1'b0; f_nack <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (cmd_wr) begin
          q <= '0; bitn <= '0; lowc <= '0; div <= DW'(CLK_DIV - 1);
          case (cmd)
            4'h2, 4'h4: begin
              state <= S_RUN; stp <= (cmd == 4'h4) ? 4'd0 : 4'd3;
              seg_q <= seg_reg; addr_q <= addr_reg; off_q <= offs_reg;
              rem <= {cnt_hi, cnt_lo}; f_low <= 1'b0; f_nack <= 1'b0;
            end
            4'hA: begin state <= S_RUN; stp <= 4'd10; f_low <= 1'b0; f_nack <= 1'b0; end
            4'h9: state <= S_CLR;
            4'hF: begin state <= S_RUN; stp <= 4'd9; end
            default: ;
          endcase
        end
        S_CLR: state <= S_IDLE;
        default: begin
          if (abort_c) begin
            stp <= 4'd9; q <= '0; bitn <= '0; lowc <= '0; div <= DW'(CLK_DIV - 1);
          end else if (hold_scl) begin
            if (lowc == LW'(LOW_TIMEOUT - 1)) begin f_low <= 1'b1; state <= S_IDLE; end
            else lowc <= lowc + LW'(1);
          end else begin
            lowc <= '0;
            if (div != '0) div <= div - DW'(1);
            else if (tick) begin
              div <= DW'(CLK_DIV - 1);
              if (kind == K_START && q == 2'd1 && !sda_i) begin
                f_low <= 1'b1; state <= S_IDLE;
              end else if (kind == K_TX && bitn == 4'd8 && q == 2'd2 && sda_i) begin
                f_nack <= 1'b1; stp <= 4'd9; q <= '0; bitn <= '0;
              end else begin
                if (kind == K_RX && q == 2'd2 && bitn < 4'd8) sh <= {sh[6:0], sda_i};
                if (kind == K_RX && q == 2'd3 && bitn == 4'd8) rem <= rem - 10'd1;
                if (q == 2'd3) begin
                  if (last_bit) begin
                    bitn <= '0;
                    if (stp == 4'd9) state <= S_IDLE; else stp <= nxt;
                  end else bitn <= bitn + 4'd1;
                end
                q <= q + 2'd1;
              end
            end
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk) if (push) mem[wp] <= sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; cnt <= '0;
    end else if (state == S_CLR) begin
      wp <= '0; rp <= '0; cnt <= '0;
    end else begin
      if (push) wp <= (wp == AW'(FIFO_DEPTH - 1)) ? '0 : wp + AW'(1);
      if (pop)  rp <= (rp == AW'(FIFO_DEPTH - 1)) ? '0 : rp + AW'(1);
      cnt <= cnt + (AW+1)'(push) - (AW+1)'(pop);
    end
  end

  a_r2_busy_after_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE && cmd_wr && (cmd == 4'h2 || cmd == 4'h4 || cmd == 4'h9 || cmd == 4'hA || cmd == 4'hF))
    |=> status[4]);
  a_r3_sda_steady_high_scl: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_RUN && (kind == K_TX || kind == K_RX || kind == K_RCV) && $past(state) == S_RUN
     && $past(scl_o) && scl_o && !$past(abort_c)) |-> $stable(sda_o));
  a_r5_rx_count_live: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_RUN && kind == K_RX) |-> rem != 10'd0);
  a_r6_nack_to_stop: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(f_nack) |-> (state == S_RUN && stp == 4'd9 && q == 2'd0));
  a_r7_low_ends_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(f_low) |-> (state == S_IDLE && scl_o && sda_o));
  a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);
endmodule

// File: tb/test_ddc_edid_reader.sv
`timescale 1ns/1ps
module test_ddc_edid_reader;
  localparam int CLK_DIV = 2;
  localparam int DEPTH   = 16;
  localparam int LOWT    = 64;
  localparam int WD      = 150000;

  logic clk = 0, rst_n = 0, cmd_wr = 0, data_rd = 0;
  logic [3:0] cmd = 0;
  logic [7:0] seg_reg = 0, addr_reg = 8'hA0, offs_reg = 0, cnt_lo = 0;
  logic [1:0] cnt_hi = 0;
  logic [7:0] data_out, status;
  logic scl_o, sda_o, scl_bus, sda_bus;
  logic force_scl_low = 0, force_sda_low = 0, s_sda = 1;

  int cyc = 0, checks = 0, fails = 0;
  logic [7:0] got[$];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  assign scl_bus = scl_o & ~force_scl_low;
  assign sda_bus = sda_o & s_sda & ~force_sda_low;

  ddc_edid_reader #(.CLK_DIV(CLK_DIV), .FIFO_DEPTH(DEPTH), .LOW_TIMEOUT(LOWT)) i_ddc_edid_reader (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd(cmd), .seg_reg(seg_reg),
    .addr_reg(addr_reg), .offs_reg(offs_reg), .cnt_lo(cnt_lo), .cnt_hi(cnt_hi),
    .data_rd(data_rd), .data_out(data_out), .status(status),
    .scl_o(scl_o), .scl_i(scl_bus), .sda_o(sda_o), .sda_i(sda_bus));

  function automatic logic [7:0] eb(input logic [7:0] s, input logic [7:0] p);
    return (s * 8'd29) ^ (p * 8'd7) ^ 8'hA5;
  endfunction

  // behavioural display memory: device 0x50 data, device 0x30 segment pointer
  logic prev_scl = 1, prev_sda = 1, sl_rd = 0, sl_first = 0;
  logic [7:0] sl_sh = 0, sl_ptr = 0, sl_seg = 0, sl_cur;
  logic [6:0] sl_dev = 0;
  int sl_st = 0, sl_bc = 0;
  always @(negedge clk) begin
    sl_cur = eb(sl_seg, sl_ptr);
    if (prev_scl && scl_bus && prev_sda && !sda_bus) begin
      sl_st = 1; sl_bc = 0; s_sda <= 1;
    end else if (prev_scl && scl_bus && !prev_sda && sda_bus) begin
      sl_st = 0; sl_seg = 0; s_sda <= 1;
    end else if (!prev_scl && scl_bus) begin
      sl_bc = sl_bc + 1;
      if (sl_bc <= 8) begin
        if (sl_st == 1 || sl_st == 2) sl_sh = {sl_sh[6:0], sda_bus};
      end else if (sl_st == 3) begin
        if (!sda_bus) sl_ptr = sl_ptr + 8'd1; else sl_st = 0;
      end
    end else if (prev_scl && !scl_bus) begin
      if (sl_bc == 8) begin
        if (sl_st == 1) begin
          if (sl_sh[7:1] == 7'h50 || sl_sh[7:1] == 7'h30) begin
            sl_dev = sl_sh[7:1]; sl_rd = sl_sh[0]; sl_first = 1; s_sda <= 0;
          end else begin sl_st = 0; s_sda <= 1; end
        end else if (sl_st == 2) begin
          s_sda <= 0;
          if (sl_dev == 7'h30) sl_seg = sl_sh;
          else if (sl_first) begin sl_ptr = sl_sh; sl_first = 0; end
        end else s_sda <= 1;
      end else if (sl_bc == 9) begin
        sl_bc = 0;
        if (sl_st == 1) sl_st = sl_rd ? 3 : 2;
        if (sl_st == 3) s_sda <= eb(sl_seg, sl_ptr) >> 7;
        else s_sda <= 1;
      end else if (sl_st == 3 && sl_bc >= 1 && sl_bc <= 7) begin
        s_sda <= sl_cur[7 - sl_bc];
      end
    end
    prev_scl = scl_bus; prev_sda = sda_bus;
  end

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  always @(posedge clk) if (cyc == WD) begin
    checks++; fails++;
    $display("FAIL R2 watchdog: run still going, actual %0d expected <%0d cycles", cyc, WD);
    summary();
    $finish;
  end

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [3:0] c);
    @(negedge clk); cmd = c; cmd_wr = 1;
    @(negedge clk); cmd_wr = 0;
  endtask

  task automatic setup(input logic [7:0] s, input logic [7:0] a, input logic [7:0] o, input int n);
    seg_reg = s; addr_reg = a; offs_reg = o; cnt_lo = n[7:0]; cnt_hi = n[9:8];
  endtask

  task automatic drain();
    got.delete();
    forever begin
      @(negedge clk);
      if (!status[2]) begin got.push_back(data_out); data_rd = 1; end
      else begin data_rd = 0; if (!status[4]) break; end
    end
    data_rd = 0;
  endtask

  task automatic wait_idle(input int lim);
    for (int i = 0; i < lim && status[4]; i++) @(negedge clk);
  endtask

  task automatic expect_bytes(input logic [7:0] s, input logic [7:0] o, input int n, input string tag);
    int bad = 0;
    for (int i = 0; i < got.size() && i < n; i++)
      if (got[i] !== eb(s, 8'(o + i))) bad++;
    chk(bad == 0, {tag, " byte mismatches"}, bad, 0);
    chk(got.size() == n, {tag, " byte count"}, got.size(), n);
  endtask

  initial begin
    int rises, t1, t2, sdalow;
    logic prev;
    repeat (5) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(status == 8'h04, "R2 R9 reset status", status, 8'h04);
    chk(scl_o && sda_o, "R7 lines released after reset", {scl_o, sda_o}, 3);

    issue(4'h5);
    chk(!status[4], "R1 unknown code ignored", status[4], 0);
    repeat (20) @(negedge clk);
    chk(!status[4] && scl_o && sda_o, "R1 unknown code leaves bus idle", {status[4], scl_o, sda_o}, 3);

    setup(8'd1, 8'hA0, 8'h80, 128);
    issue(4'h4);
    chk(status[4], "R2 busy after segment read", status[4], 1);
    drain();
    expect_bytes(8'd1, 8'h80, 128, "R4 segment read block 3");

    setup(8'd5, 8'hA0, 8'h80, 128);
    issue(4'h2);
    drain();
    expect_bytes(8'd0, 8'h80, 128, "R3 plain read");

    setup(8'd2, 8'hA0, 8'h10, 1);
    issue(4'h4);
    drain();
    expect_bytes(8'd2, 8'h10, 1, "R5 single byte NACK");

    setup(8'd0, 8'hA0, 8'h33, 0);
    issue(4'h2);
    drain();
    chk(got.size() == 0 && status[5] == 0, "R5 zero count", got.size(), 0);

    setup(8'd0, 8'hA0, 8'hF0, 300);
    issue(4'h2);
    drain();
    expect_bytes(8'd0, 8'hF0, 300, "R5 ten-bit count");

    setup(8'd0, 8'h70, 8'h00, 4);
    issue(4'h2);
    drain();
    chk(status[5] && !status[6], "R6 no ack flag", status, 8'h24);
    chk(got.size() == 0, "R6 no data after no ack", got.size(), 0);
    setup(8'd0, 8'hA0, 8'h07, 1);
    issue(4'h2);
    drain();
    chk(!status[5], "R6 flag cleared by next read", status[5], 0);
    expect_bytes(8'd0, 8'h07, 1, "R6 read after fault");

    setup(8'd0, 8'hA0, 8'h00, 20);
    issue(4'h2);
    repeat (1800) @(negedge clk);
    chk(status[4] && !scl_o && !status[2], "R9 full FIFO holds SCL low", {status[4], scl_o, status[2]}, 4);
    drain();
    expect_bytes(8'd0, 8'h00, 20, "R9 no byte lost");

    setup(8'd0, 8'hA0, 8'h40, 5);
    issue(4'h2);
    wait_idle(2000);
    chk(!status[2], "R9 data present", status[2], 0);
    issue(4'h9);
    chk(status[4], "R2 busy during clear", status[4], 1);
    @(negedge clk);
    chk(!status[4] && status[2], "R10 clear empties FIFO", {status[4], status[2]}, 1);

    setup(8'd0, 8'hA0, 8'h20, 10);
    issue(4'h2);
    repeat (200) @(negedge clk);
    issue(4'h9);
    drain();
    expect_bytes(8'd0, 8'h20, 10, "R1 clear ignored while busy");

    setup(8'd0, 8'hA0, 8'h00, 128);
    issue(4'h2);
    repeat (60) @(negedge clk);
    issue(4'hF);
    wait_idle(100);
    chk(!status[4] && !status[5] && scl_o && sda_o, "R11 abort ends transfer",
        {status[4], status[5], scl_o, sda_o}, 3);
    chk(status[2], "R11 no data after abort", status[2], 1);

    force_scl_low = 1;
    setup(8'd0, 8'hA0, 8'h00, 4);
    issue(4'h2);
    wait_idle(400);
    chk(status[6] && !status[4] && scl_o && sda_o, "R7 SCL stuck low", status, 8'h44);
    force_scl_low = 0;

    force_sda_low = 1;
    issue(4'h2);
    wait_idle(400);
    chk(status[6] && !status[4], "R7 SDA low at start", status, 8'h44);
    force_sda_low = 0;

    rises = 0; t1 = 0; t2 = 0; sdalow = 0; prev = 1;
    issue(4'hA);
    do begin
      @(negedge clk);
      if (!prev && scl_o) begin
        rises++;
        if (rises == 1) t1 = cyc;
        if (rises == 2) t2 = cyc;
      end
      if (rises < 9 && !sda_o) sdalow++;
      prev = scl_o;
    end while (status[4] && cyc < WD);
    chk(rises == 10, "R8 nine pulses plus STOP", rises, 10);
    chk(sdalow == 0, "R8 SDA released while clocking", sdalow, 0);
    chk(t2 - t1 == 4 * CLK_DIV, "R12 SCL period", t2 - t1, 4 * CLK_DIV);
    chk(!status[6] && scl_o && sda_o, "R7 flag cleared by recovery", status[6], 0);

    summary();
    $finish;
  end
endmodule